// File: doc/BRIEF.md
# Parity-Checked Table-Driven State Machine

This block is a synchronous state machine whose next-state and output functions are not built from gates. Both come from a read-only lookup table addressed by the current state concatenated with the input vector. Each table word holds the next-state code, the output value and one parity bit. A concurrent checker examines the word that is read in every cycle. A fault anywhere between the stored bits and the state register shows up as a parity mismatch. This covers a damaged table cell, a broken address path and a corrupted read bus. When one-hot state encoding is chosen, the checker also watches the live state vector. If that vector has no bit set, or more than one, the checker flags it.

Detection is latched into a sticky error flag that only reset clears. The machine is a ring sequencer with four commands: hold, step forward, step backward and return home. Its output encodes the state it is entering together with the command that moved it there. A test-only fault mask input XORs any pattern of bits into the word as it is read. A bench can use it to show that the checker catches single faults, that it catches multi-hot state vectors parity cannot see, and that it is blind to even-count output faults. Recovery and table scrubbing are left to logic outside the block.

Top module: `prom_fsm`

## Requirements
- R1: While `rst` is high at a rising edge, the state register loads the home state (one-hot code with only bit 0 set, 4'b0001 by default), `out_q` loads zero and `err_q` clears.
- R2: With a valid state of index i among ST_N states, the command in `in_vec[1:0]` selects the next state: 0 holds i, 1 moves to (i+1) mod ST_N, 2 moves to (i-1) mod ST_N, 3 moves to index 0.
- R3: `out_q` is registered and updates at the same edge as the state. Its value is (next_index * 2^IN_W + in_vec) mod 2^OUT_W.
- R4: The table word layout is: bits [OUT_W-1:0] are the output, bits [OUT_W+SW-1:OUT_W] are the next-state code, and the top bit is chosen so the whole word has even parity. `fault_mask` is XORed bit for bit into the word read in the same cycle, and the result is what gets registered and checked.
- R5: A read word with odd parity sets `err_q` at the same edge that loads that word's contents into `state_q` and `out_q`.
- R6: Once `err_q` is set, it stays high through any later inputs until a reset.
- R7: In one-hot mode, a state vector with zero bits or more than one bit set sets `err_q` at the next edge, even when the word read in that cycle has correct parity.
- R8: A mask that flips an even number of bits, all inside the output field, leaves `err_q` low. The corrupted output value still appears on `out_q`.
- R9: A table entry addressed by an invalid state code holds the home state and a zero output with correct parity. With a clean mask, an invalid state is therefore followed by the home state and `out_q` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vec | input | IN_W | Machine inputs; low two bits are the command |
| fault_mask | input | WORD_W | Test-only XOR mask applied to the word read this cycle |
| out_q | output | OUT_W | Registered machine outputs |
| state_q | output | SW | Current state code |
| err_q | output | 1 | Sticky fault flag |

## Verification
The hardest case to reach from the ports is a state vector that is multi-hot or empty while parity stays correct. A correct table never produces such a vector. A single flipped bit always trips parity first and sets the sticky flag, which hides anything the one-hot check would add. The stimulus reaches the case by flipping one next-state bit and the parity bit together. The bench first checks that `err_q` stays low at the edge that loads the bad vector. It then checks that the flag rises one edge later and that the machine returns to its home state. Reset then clears the flag so the empty-vector case can be tested the same way.

// File: rtl/prom_fsm_pkg.sv
package prom_fsm_pkg;

  typedef enum logic [1:0] {
    CMD_HOLD = 2'd0,
    CMD_FWD  = 2'd1,
    CMD_BACK = 2'd2,
    CMD_HOME = 2'd3
  } cmd_e;

  // Index of a ring neighbour selected by a command.
  function automatic int step_index(input int idx, input int n, input cmd_e cmd);
    int r;
    case (cmd)
      CMD_HOLD: r = idx;
      CMD_FWD:  r = (idx + 1) % n;
      CMD_BACK: r = (idx + n - 1) % n;
      default:  r = 0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/prom_fsm_table.sv
module prom_fsm_table
  import prom_fsm_pkg::*;
#(
  parameter int ST_N   = 4,
  parameter int IN_W   = 2,
  parameter int OUT_W  = 4,
  parameter bit ONEHOT = 1'b1,
  parameter int SW     = ONEHOT ? ST_N : $clog2(ST_N),
  parameter int WORD_W = SW + OUT_W + 1
) (
  input  logic [SW+IN_W-1:0] addr,
  output logic [WORD_W-1:0]  word
);

  localparam int AW    = SW + IN_W;
  localparam int DEPTH = 1 << AW;
  localparam logic [SW-1:0] HOME = ONEHOT ? SW'(1) : '0;

  // Decoded index of a state code, or -1 when the code is invalid.
  function automatic int code_to_index(input logic [SW-1:0] code);
    int idx;
    int ones;
    idx  = -1;
    ones = 0;
    if (ONEHOT) begin
      for (int b = 0; b < SW; b++) begin
        if (code[b]) begin
          ones = ones + 1;
          idx  = b;
        end
      end
      if (ones != 1) idx = -1;
    end else begin
      idx = (int'(code) < ST_N) ? int'(code) : -1;
    end
    return idx;
  endfunction

  function automatic logic [SW-1:0] index_to_code(input int idx);
    logic [SW-1:0] c;
    if (ONEHOT) c = SW'(1) << idx;
    else        c = SW'(idx);
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] build_word(input int a);
    logic [AW-1:0]    av;
    logic [SW-1:0]    cur;
    logic [IN_W-1:0]  inp;
    logic [SW-1:0]    nxt;
    logic [OUT_W-1:0] ov;
    int               idx;
    int               nidx;
    av   = AW'(a);
    cur  = av[AW-1:IN_W];
    inp  = av[IN_W-1:0];
    idx  = code_to_index(cur);
    if (idx < 0) begin
      nxt = HOME;
      ov  = '0;
    end else begin
      nidx = step_index(idx, ST_N, cmd_e'(inp[1:0]));
      nxt  = index_to_code(nidx);
      ov   = OUT_W'((nidx << IN_W) + int'(inp));
    end
    return {^{nxt, ov}, nxt, ov};
  endfunction

  logic [WORD_W-1:0] rom [DEPTH];

  // Constant contents, one entry per address, computed at elaboration.
  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign rom[g] = build_word(g);
  end

  assign word = rom[addr];

endmodule

// File: rtl/prom_fsm_check.sv
module prom_fsm_check #(
  parameter int ST_N   = 4,
  parameter bit ONEHOT = 1'b1,
  parameter int SW     = ONEHOT ? ST_N : $clog2(ST_N),
  parameter int WORD_W = SW + 5
) (
  input  logic [WORD_W-1:0] word,
  input  logic [SW-1:0]     state,
  output logic              parity_bad,
  output logic              state_bad
);

  // Stored words carry even parity over every bit, parity bit included.
  assign parity_bad = ^word;

  if (ONEHOT) begin : g_onehot
    assign state_bad = ($countones(state) != 1);
  end else begin : g_binary
    assign state_bad = (int'(state) >= ST_N);
  end

endmodule

// File: rtl/prom_fsm.sv
module prom_fsm
  import prom_fsm_pkg::*;
#(
  parameter int ST_N   = 4,
  parameter int IN_W   = 2,
  parameter int OUT_W  = 4,
  parameter bit ONEHOT = 1'b1,
  localparam int SW    = ONEHOT ? ST_N : $clog2(ST_N),
  localparam int WORD_W = SW + OUT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IN_W-1:0]   in_vec,
  input  logic [WORD_W-1:0] fault_mask,
  output logic [OUT_W-1:0]  out_q,
  output logic [SW-1:0]     state_q,
  output logic              err_q
);

  localparam logic [SW-1:0] HOME = ONEHOT ? SW'(1) : '0;

  logic [SW-1:0]     state_r;
  logic [OUT_W-1:0]  out_r;
  logic              err_r;
  logic [WORD_W-1:0] rom_word;
  logic [WORD_W-1:0] rd_word;
  logic              parity_bad;
  logic              state_bad;

  prom_fsm_table #(
    .ST_N(ST_N), .IN_W(IN_W), .OUT_W(OUT_W), .ONEHOT(ONEHOT),
    .SW(SW), .WORD_W(WORD_W)
  ) u_table (
    .addr ({state_r, in_vec}),
    .word (rom_word)
  );

  assign rd_word = rom_word ^ fault_mask;

  prom_fsm_check #(
    .ST_N(ST_N), .ONEHOT(ONEHOT), .SW(SW), .WORD_W(WORD_W)
  ) u_check (
    .word       (rd_word),
    .state      (state_r),
    .parity_bad (parity_bad),
    .state_bad  (state_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_r <= HOME;
      out_r   <= '0;
      err_r   <= 1'b0;
    end else begin
      state_r <= rd_word[OUT_W +: SW];
      out_r   <= rd_word[OUT_W-1:0];
      err_r   <= err_r | parity_bad | state_bad;
    end
  end

  assign state_q = state_r;
  assign out_q   = out_r;
  assign err_q   = err_r;

endmodule

// File: rtl/prom_fsm_sva.sv
module prom_fsm_sva #(
  parameter int ST_N   = 4,
  parameter int IN_W   = 2,
  parameter int OUT_W  = 4,
  parameter bit ONEHOT = 1'b1,
  parameter int SW     = ONEHOT ? ST_N : $clog2(ST_N),
  parameter int WORD_W = SW + OUT_W + 1
) (
  input logic              clk,
  input logic              rst,
  input logic [IN_W-1:0]   in_vec,
  input logic [WORD_W-1:0] fault_mask,
  input logic [OUT_W-1:0]  out_q,
  input logic [SW-1:0]     state_q,
  input logic              err_q
);

  localparam logic [SW-1:0] HOME = ONEHOT ? SW'(1) : '0;

  logic st_ok;
  if (ONEHOT) begin : g_ok_oh
    assign st_ok = $onehot(state_q);
  end else begin : g_ok_bin
    assign st_ok = (int'(state_q) < ST_N);
  end

  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);

  p_odd_mask_r5: assert property (@(posedge clk) disable iff (rst)
    (^fault_mask) |=> err_q);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (st_ok && in_vec[1:0] == 2'd0 && fault_mask == '0) |=> $stable(state_q));

  p_bad_state_r7: assert property (@(posedge clk) disable iff (rst)
    !st_ok |=> err_q);

  p_bad_state_home_r9: assert property (@(posedge clk) disable iff (rst)
    (!st_ok && fault_mask == '0) |=> (state_q == HOME && out_q == '0));

endmodule

bind prom_fsm prom_fsm_sva #(
  .ST_N(ST_N), .IN_W(IN_W), .OUT_W(OUT_W), .ONEHOT(ONEHOT),
  .SW(SW), .WORD_W(WORD_W)
) u_sva (
  .clk(clk), .rst(rst), .in_vec(in_vec), .fault_mask(fault_mask),
  .out_q(out_q), .state_q(state_q), .err_q(err_q)
);

// File: tb/prom_fsm_bench.sv
module prom_fsm_bench;

  localparam int ST_N  = 4;
  localparam int IN_W  = 2;
  localparam int OUT_W = 4;
  localparam int SW    = ST_N;
  localparam int WW    = SW + OUT_W + 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [IN_W-1:0]   in_vec = '0;
  logic [WW-1:0]     fault_mask = '0;
  logic [OUT_W-1:0]  out_q;
  logic [SW-1:0]     state_q;
  logic              err_q;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [SW-1:0]    e_state;
  logic [OUT_W-1:0] e_out;
  logic             e_err;

  always #10 clk = ~clk;

  prom_fsm u_prom_fsm (
    .clk(clk), .rst(rst), .in_vec(in_vec), .fault_mask(fault_mask),
    .out_q(out_q), .state_q(state_q), .err_q(err_q)
  );

  // Expected table word from the requirements (R2, R3, R4, R9).
  function automatic logic [WW-1:0] model_word(input logic [SW-1:0] st, input logic [IN_W-1:0] iv);
    int idx;
    int nidx;
    logic [SW-1:0] ns;
    logic [OUT_W-1:0] ov;
    idx = -1;
    if ($countones(st) == 1)
      for (int b = 0; b < SW; b++) if (st[b]) idx = b;
    if (idx < 0) begin
      ns = SW'(1);
      ov = '0;
    end else begin
      case (iv[1:0])
        2'd0: nidx = idx;
        2'd1: nidx = (idx + 1) % ST_N;
        2'd2: nidx = (idx + ST_N - 1) % ST_N;
        default: nidx = 0;
      endcase
      ns = SW'(1) << nidx;
      ov = OUT_W'(nidx * (1 << IN_W) + int'(iv));
    end
    return {^{ns, ov}, ns, ov};
  endfunction

  task automatic check(input string req);
    n_vec++;
    if (state_q !== e_state || out_q !== e_out || err_q !== e_err) begin
      n_fail++;
      $display("FAIL %s: state=%b out=%h err=%b expected state=%b out=%h err=%b",
               req, state_q, out_q, err_q, e_state, e_out, e_err);
    end
  endtask

  // Called just after a falling edge; drives, clocks, checks.
  task automatic tick(input logic [IN_W-1:0] iv, input logic [WW-1:0] m, input string req);
    logic [WW-1:0] w;
    logic flt;
    in_vec = iv;
    fault_mask = m;
    @(posedge clk);
    if (rst) begin
      e_state = SW'(1);
      e_out   = '0;
      e_err   = 1'b0;
    end else begin
      w   = model_word(e_state, iv) ^ m;
      flt = (^w) | ($countones(e_state) != 1);
      e_state = w[OUT_W +: SW];
      e_out   = w[OUT_W-1:0];
      e_err   = e_err | flt;
    end
    #5;
    check(req);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick('0, '0, "R1");
    rst = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    end
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5EED;
    void'($urandom(seed));
    e_state = SW'(1); e_out = '0; e_err = 1'b0;
    @(negedge clk);
    do_reset();
    do_reset();

    // R2 directed: backward wrap from home, forward, home, hold
    tick(2'd2, '0, "R2 back wrap");
    tick(2'd1, '0, "R2 fwd wrap");
    tick(2'd1, '0, "R3 fwd");
    tick(2'd0, '0, "R2 hold");
    tick(2'd3, '0, "R2 home");

    // R2/R3 random clean traffic
    for (int i = 0; i < 400; i++) tick(IN_W'($urandom), '0, "R2_R3 random");

    // R8: two output bits flipped, parity blind
    tick(2'd1, WW'(9'b0_0000_0011), "R8 even out flip");
    tick(2'd0, '0, "R8 follow");

    // R7/R9: next-state bit plus parity bit flipped -> multi-hot state
    do_reset();
    tick(2'd0, WW'(9'b1_0100_0000), "R7 multi-hot load, parity ok");
    tick(2'd1, '0, "R7 multi-hot flagged / R9 home");
    tick(2'd1, '0, "R6 sticky after R7");

    // R7/R9: empty state vector
    do_reset();
    tick(2'd0, WW'(9'b1_0001_0000), "R7 empty load, parity ok");
    tick(2'd2, '0, "R7 empty flagged / R9 home");

    // R5: single-bit flips at each position, reset between
    for (int b = 0; b < WW; b++) begin
      do_reset();
      tick(2'd1, WW'(1) << b, "R5 single flip");
    end

    // R6: sticky through clean cycles, cleared by reset (R1)
    for (int i = 0; i < 20; i++) tick(IN_W'($urandom), '0, "R6 sticky");
    do_reset();

    // R4/R5 mixed random faults with periodic resets
    for (int i = 0; i < 400; i++) begin
      logic [WW-1:0] m;
      m = '0;
      if ($urandom_range(0, 7) == 0) m = WW'($urandom);
      if ($urandom_range(0, 31) == 0) do_reset();
      else tick(IN_W'($urandom), m, "R4 random mask");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule